// File: doc/BRIEF.md
# Buffer Descriptor Ping-Pong Manager

This block sits between a USB protocol engine and shared system memory. It decides which data buffer serves each transaction. Each endpoint and direction owns a pair of 8-byte descriptors, one even and one odd, held in a table in memory. The protocol engine names an endpoint and a direction. The block forms the descriptor address from a 512-byte-aligned table base and a per-pair even/odd pointer. It reads the descriptor over a simple request/acknowledge memory port and checks the ownership flag. It then returns the buffer address and byte count, a not-ready outcome, or a rejection.

Hardware may use a descriptor only while its ownership flag is set. When the engine reports that a transaction has finished, the block writes back the actual byte count and clears the flag, which hands the descriptor back to software. It then moves that pair to its other buffer. Software can therefore refill one buffer while the engine works on the other.

Requests are rejected without any memory access in two cases: the endpoint is disabled, or the block is in host mode and the request names any endpoint other than 0.

Top module: `bd_pingpong_mgr`

## Requirements
- R1: A descriptor read addresses `{cfg_base, ep, dir, odd, word, 2'b00}`. Here `dir` is 1 for transmit, `odd` is the pair's current pointer, and `word` is 0 for the first word and 1 for the second. `mem_req` stays high with a stable address until `mem_ack`.
- R2: The first word holds the ownership flag in bit 7 and the byte count in bits 25:16. The second word holds the buffer address. When the flag is set, the block reads both words and then gives one response with `rsp_ok`, that count, that address and the pointer value in `rsp_odd`.
- R3: When the flag is clear, the block reads only the first word and responds with `rsp_nak`. The pair's pointer stays unchanged, so the next request reads the same descriptor.
- R4: A request to an endpoint whose `cfg_ep_en` bit is 0 gets `rsp_reject` one cycle after it is accepted, with no memory access.
- R5: With `cfg_host` high, a request to any endpoint other than 0 is rejected with no memory access. An enabled endpoint 0 is served normally.
- R6: After `done_valid`, the block writes the first word back in place. The write puts `done_cnt` in bits 25:16, clears bit 7 and keeps every other bit as read.
- R7: Once the write-back is acknowledged, the pointer of that endpoint and direction flips, and only that pointer. Successive completions on one pair alternate between even and odd.
- R8: Reset sets all pointers to even. Reset starts no memory access, so descriptors in memory keep their contents.
- R9: `req_ready` is high only when the block is idle. A request offered while `req_ready` is low is dropped and produces no response and no memory access.
- R10: `rsp_valid` is a one-cycle pulse, and exactly one of `rsp_ok`, `rsp_nak` or `rsp_reject` is high with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base | input | ADDR_W-log2(NUM_EP)-5 | Upper address bits of the descriptor table |
| cfg_ep_en | input | NUM_EP | Per-endpoint enable |
| cfg_host | input | 1 | Host mode: endpoint 0 only |
| req_valid | input | 1 | Lookup request |
| req_ready | output | 1 | Block idle, request accepted |
| req_ep | input | log2(NUM_EP) | Endpoint number |
| req_tx | input | 1 | 1 = transmit, 0 = receive |
| rsp_valid | output | 1 | Response pulse |
| rsp_ok | output | 1 | Buffer granted |
| rsp_nak | output | 1 | Descriptor owned by software |
| rsp_reject | output | 1 | Endpoint disabled or illegal in host mode |
| rsp_odd | output | 1 | Pointer value used |
| rsp_buf_addr | output | 32 | Buffer address from the descriptor |
| rsp_byte_cnt | output | CNT_W | Byte count from the descriptor |
| done_valid | input | 1 | Granted transaction finished |
| done_cnt | input | CNT_W | Bytes actually moved |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete, read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The bench builds the block with NUM_EP = 4. This shrinks the descriptor table to 32 words, so the bench memory model can hold the whole table. Every endpoint, direction and even/odd half can then be swept, and every pointer can be flipped and flipped back within a short run. Expected addresses, counts and written-back words are computed arithmetically from each descriptor's index. The bench also sweeps the enable mask and host mode over all four endpoints.

// File: rtl/bdm_pkg.sv
package bdm_pkg;
  localparam int OWN_BIT = 7;
  localparam int CNT_LSB = 16;
  localparam int WORD_W  = 32;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD0,
    S_RD1,
    S_XFER,
    S_WB
  } bdm_state_t;
endpackage

// File: rtl/bdm_gate.sv
module bdm_gate #(
  parameter int NUM_EP = 16,
  localparam int EPW = $clog2(NUM_EP)
) (
  input  logic [NUM_EP-1:0] ep_en,
  input  logic              host,
  input  logic [EPW-1:0]    ep,
  output logic              allow
);
  always_comb begin
    allow = ep_en[ep];
    if (host && (ep != '0)) allow = 1'b0;
  end
endmodule

// File: rtl/bdm_addr.sv
module bdm_addr #(
  parameter int NUM_EP = 16,
  parameter int ADDR_W = 32,
  localparam int EPW    = $clog2(NUM_EP),
  localparam int LOW_W  = EPW + 5,
  localparam int BASE_W = ADDR_W - LOW_W
) (
  input  logic [BASE_W-1:0] base,
  input  logic [EPW-1:0]    ep,
  input  logic              tx,
  input  logic              odd,
  input  logic              word_sel,
  output logic [ADDR_W-1:0] addr
);
  always_comb addr = {base, ep, tx, odd, word_sel, 2'b00};
endmodule

// File: rtl/bdm_pp.sv
module bdm_pp #(
  parameter int NUM_EP = 16,
  localparam int IDX_W  = $clog2(NUM_EP) + 1,
  localparam int NUM_PP = 2 * NUM_EP
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_odd,
  input  logic             tgl_en,
  input  logic [IDX_W-1:0] tgl_idx
);
  logic [NUM_PP-1:0] bits;

  for (genvar i = 0; i < NUM_PP; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                                    bits[i] <= 1'b0;
      else if (tgl_en && (tgl_idx == IDX_W'(i)))  bits[i] <= ~bits[i];
    end
  end

  assign rd_odd = bits[rd_idx];

  a_r8_reset_even: assert property (@(posedge clk) rst |=> (bits == '0));
  a_r7_single_flip: assert property (@(posedge clk) disable iff (rst)
    tgl_en |=> ($countones(bits ^ $past(bits)) == 1));
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !tgl_en |=> $stable(bits));
endmodule

// File: rtl/bd_pingpong_mgr.sv
module bd_pingpong_mgr
  import bdm_pkg::*;
#(
  parameter int NUM_EP = 16,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 10
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [ADDR_W-$clog2(NUM_EP)-6:0] cfg_base,
  input  logic [NUM_EP-1:0]               cfg_ep_en,
  input  logic                            cfg_host,
  input  logic                            req_valid,
  output logic                            req_ready,
  input  logic [$clog2(NUM_EP)-1:0]       req_ep,
  input  logic                            req_tx,
  output logic                            rsp_valid,
  output logic                            rsp_ok,
  output logic                            rsp_nak,
  output logic                            rsp_reject,
  output logic                            rsp_odd,
  output logic [31:0]                     rsp_buf_addr,
  output logic [CNT_W-1:0]                rsp_byte_cnt,
  input  logic                            done_valid,
  input  logic [CNT_W-1:0]                done_cnt,
  output logic                            mem_req,
  output logic                            mem_we,
  output logic [ADDR_W-1:0]               mem_addr,
  output logic [31:0]                     mem_wdata,
  input  logic                            mem_ack,
  input  logic [31:0]                     mem_rdata
);
  localparam int EPW   = $clog2(NUM_EP);
  localparam int LOW_W = EPW + 5;

  bdm_state_t       state;
  logic [EPW-1:0]   ep_q;
  logic             tx_q;
  logic             odd_q;
  logic [31:0]      w0_q;
  logic [CNT_W-1:0] dcnt_q;
  logic             allow;
  logic             cur_odd;
  logic             accept;
  logic             pp_tgl;

  bdm_gate #(.NUM_EP(NUM_EP)) u_gate (
    .ep_en (cfg_ep_en),
    .host  (cfg_host),
    .ep    (req_ep),
    .allow (allow)
  );

  bdm_pp #(.NUM_EP(NUM_EP)) u_pp (
    .clk     (clk),
    .rst     (rst),
    .rd_idx  ({req_ep, req_tx}),
    .rd_odd  (cur_odd),
    .tgl_en  (pp_tgl),
    .tgl_idx ({ep_q, tx_q})
  );

  bdm_addr #(.NUM_EP(NUM_EP), .ADDR_W(ADDR_W)) u_addr (
    .base     (cfg_base),
    .ep       (ep_q),
    .tx       (tx_q),
    .odd      (odd_q),
    .word_sel (state == S_RD1),
    .addr     (mem_addr)
  );

  assign req_ready = (state == S_IDLE) && !rsp_valid;
  assign accept    = req_valid && req_ready;
  assign pp_tgl    = (state == S_WB) && mem_ack;
  assign mem_req   = (state == S_RD0) || (state == S_RD1) || (state == S_WB);
  assign mem_we    = (state == S_WB);

  always_comb begin
    mem_wdata = w0_q;
    mem_wdata[CNT_LSB +: CNT_W] = dcnt_q;
    mem_wdata[OWN_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_IDLE;
      ep_q         <= '0;
      tx_q         <= 1'b0;
      odd_q        <= 1'b0;
      w0_q         <= '0;
      dcnt_q       <= '0;
      rsp_valid    <= 1'b0;
      rsp_ok       <= 1'b0;
      rsp_nak      <= 1'b0;
      rsp_reject   <= 1'b0;
      rsp_odd      <= 1'b0;
      rsp_buf_addr <= '0;
      rsp_byte_cnt <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        S_IDLE: if (accept) begin
          ep_q  <= req_ep;
          tx_q  <= req_tx;
          odd_q <= cur_odd;
          if (!allow) begin
            rsp_valid  <= 1'b1;
            rsp_ok     <= 1'b0;
            rsp_nak    <= 1'b0;
            rsp_reject <= 1'b1;
            rsp_odd    <= cur_odd;
          end else begin
            state <= S_RD0;
          end
        end
        S_RD0: if (mem_ack) begin
          w0_q         <= mem_rdata;
          rsp_byte_cnt <= mem_rdata[CNT_LSB +: CNT_W];
          if (!mem_rdata[OWN_BIT]) begin
            rsp_valid  <= 1'b1;
            rsp_ok     <= 1'b0;
            rsp_nak    <= 1'b1;
            rsp_reject <= 1'b0;
            rsp_odd    <= odd_q;
            state      <= S_IDLE;
          end else begin
            state <= S_RD1;
          end
        end
        S_RD1: if (mem_ack) begin
          rsp_buf_addr <= mem_rdata;
          rsp_valid    <= 1'b1;
          rsp_ok       <= 1'b1;
          rsp_nak      <= 1'b0;
          rsp_reject   <= 1'b0;
          rsp_odd      <= odd_q;
          state        <= S_XFER;
        end
        S_XFER: if (done_valid) begin
          dcnt_q <= done_cnt;
          state  <= S_WB;
        end
        S_WB: if (mem_ack) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r1_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  a_r1_table_base: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[ADDR_W-1:LOW_W] == cfg_base) && (mem_addr[1:0] == 2'b00));
  a_r5_host_ep0: assert property (@(posedge clk) disable iff (rst)
    (mem_req && cfg_host) |-> (mem_addr[LOW_W-1:5] == '0));
  a_r6_own_released: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> !mem_wdata[OWN_BIT]);
  a_r4_reject_no_mem: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_reject) |-> !$past(mem_req));
  a_r10_one_outcome: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($countones({rsp_ok, rsp_nak, rsp_reject}) == 1));
  a_r10_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  a_r9_busy: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !req_ready);
endmodule

// File: tb/sim_bd_pingpong_mgr.sv
`timescale 1ns/1ps
module sim_bd_pingpong_mgr;
  localparam int NEP = 4;
  localparam int BW  = 32 - 2 - 5;
  localparam logic [BW-1:0] BASE = 25'h0ABCDE;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NEP-1:0] cfg_ep_en = '1;
  logic cfg_host = 1'b0;
  logic req_valid = 1'b0, req_tx = 1'b0;
  logic [1:0] req_ep = '0;
  logic req_ready, rsp_valid, rsp_ok, rsp_nak, rsp_reject, rsp_odd;
  logic [31:0] rsp_buf_addr;
  logic [9:0] rsp_byte_cnt;
  logic done_valid = 1'b0;
  logic [9:0] done_cnt = '0;
  logic mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;

  logic [31:0] mem [0:31];
  int acc_cnt = 0;
  int rsp_cnt = 0;
  logic [31:0] last_addr = '0, prev_addr = '0;
  int n_chk = 0, n_fail = 0;
  bit r_ok, r_nak, r_rej, r_odd;
  logic [31:0] r_buf;
  logic [9:0] r_cnt;

  always #2.5 clk = ~clk;

  bd_pingpong_mgr #(.NUM_EP(NEP), .ADDR_W(32), .CNT_W(10)) u0 (
    .clk(clk), .rst(rst), .cfg_base(BASE), .cfg_ep_en(cfg_ep_en), .cfg_host(cfg_host),
    .req_valid(req_valid), .req_ready(req_ready), .req_ep(req_ep), .req_tx(req_tx),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_nak(rsp_nak), .rsp_reject(rsp_reject),
    .rsp_odd(rsp_odd), .rsp_buf_addr(rsp_buf_addr), .rsp_byte_cnt(rsp_byte_cnt),
    .done_valid(done_valid), .done_cnt(done_cnt),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      acc_cnt <= acc_cnt + 1;
      if (mem_we) mem[mem_addr[6:2]] <= mem_wdata;
      else begin
        mem_rdata <= mem[mem_addr[6:2]];
        prev_addr <= last_addr;
        last_addr <= mem_addr;
      end
    end
  end

  always @(negedge clk) if (rsp_valid) rsp_cnt = rsp_cnt + 1;

  function automatic logic [9:0] cnt_of(int idx);
    return 10'(idx * 37 + 5);
  endfunction
  function automatic logic [31:0] w0_of(int idx, bit own);
    return {6'(idx + 40), cnt_of(idx), 8'(idx * 3 + 8'h51), own, 7'h15};
  endfunction
  function automatic logic [31:0] w1_of(int idx);
    return 32'h2000_0000 + 32'(idx) * 32'h100;
  endfunction
  function automatic logic [31:0] daddr(int e, int d, int o, int w);
    return {BASE, 2'(e), 1'(d), 1'(o), 1'(w), 2'b00};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_own_all();
    for (int i = 0; i < 16; i++) mem[2*i][7] = 1'b1;
  endtask

  task automatic do_req(int e, int d);
    int t = 0;
    @(negedge clk);
    while (!req_ready && t < 100) begin @(negedge clk); t++; end
    req_valid = 1'b1; req_ep = 2'(e); req_tx = 1'(d);
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (!rsp_valid && t < 100) begin @(negedge clk); t++; end
    r_ok = rsp_ok; r_nak = rsp_nak; r_rej = rsp_reject; r_odd = rsp_odd;
    r_buf = rsp_buf_addr; r_cnt = rsp_byte_cnt;
    chk("R10 response seen", 64'(rsp_valid), 64'd1);
    chk("R10 one outcome", 64'(int'(r_ok) + int'(r_nak) + int'(r_rej)), 64'd1);
    @(negedge clk);
    chk("R10 pulse width", 64'(rsp_valid), 64'd0);
  endtask

  task automatic complete(logic [9:0] c);
    int t = 0;
    @(negedge clk);
    done_valid = 1'b1; done_cnt = c;
    @(negedge clk);
    done_valid = 1'b0;
    while (!req_ready && t < 100) begin @(negedge clk); t++; end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int a0, idx, r0;
    for (int i = 0; i < 16; i++) begin
      mem[2*i]   = w0_of(i, 1'b1);
      mem[2*i+1] = w1_of(i);
    end
    repeat (3) @(negedge clk);
    chk("R8 no access in reset", 64'(acc_cnt), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 ready after reset", 64'(req_ready), 64'd1);
    chk("R10 no response after reset", 64'(rsp_valid), 64'd0);
    chk("R8 no mem_req after reset", 64'(mem_req), 64'd0);

    // R1 R2 R6 R7: full sweep, both halves
    for (int p = 0; p < 2; p++)
      for (int e = 0; e < NEP; e++)
        for (int d = 0; d < 2; d++) begin
          idx = e*4 + d*2 + p;
          a0 = acc_cnt;
          do_req(e, d);
          chk("R2 ok", 64'(r_ok), 64'd1);
          chk("R2 buffer address", 64'(r_buf), 64'(w1_of(idx)));
          chk("R2 byte count", 64'(r_cnt), 64'(cnt_of(idx)));
          chk("R7 pointer half", 64'(r_odd), 64'(p));
          chk("R1 first word addr", 64'(prev_addr), 64'(daddr(e, d, p, 0)));
          chk("R1 second word addr", 64'(last_addr), 64'(daddr(e, d, p, 1)));
          chk("R2 two reads", 64'(acc_cnt - a0), 64'd2);
          complete(10'(idx * 11 + 1));
          chk("R6 write-back word", 64'(mem[2*idx]),
              64'({6'(idx + 40), 10'(idx * 11 + 1), 8'(idx * 3 + 8'h51), 1'b0, 7'h15}));
          chk("R6 second word untouched", 64'(mem[2*idx+1]), 64'(w1_of(idx)));
        end

    // R3: owner is software, pointer stays
    for (int k = 0; k < 2; k++) begin
      a0 = acc_cnt;
      do_req(2, 0);
      chk("R3 nak", 64'(r_nak), 64'd1);
      chk("R3 single read", 64'(acc_cnt - a0), 64'd1);
      chk("R3 same descriptor", 64'(last_addr), 64'(daddr(2, 0, 0, 0)));
    end
    mem[2*8][7] = 1'b1;
    do_req(2, 0);
    chk("R3 ok after handback", 64'(r_ok), 64'd1);
    chk("R3 pointer unchanged by nak", 64'(r_odd), 64'd0);
    complete(10'd3);

    // R7: only this pair flipped
    mem[2*9][7] = 1'b1; mem[2*10][7] = 1'b1;
    do_req(2, 1);
    chk("R7 other pair unaffected", 64'(r_odd), 64'd0);
    complete(10'd4);

    // R8: reset returns pointers to even, leaves memory alone
    @(negedge clk);
    rst = 1'b1;
    a0 = acc_cnt;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 reset no access", 64'(acc_cnt - a0), 64'd0);
    chk("R8 memory kept", 64'(mem[2*8][7]), 64'd0);
    mem[2*8][7] = 1'b1;
    do_req(2, 0);
    chk("R8 pointer even", 64'(r_odd), 64'd0);
    chk("R8 even address", 64'(prev_addr), 64'(daddr(2, 0, 0, 0)));
    complete(10'd5);

    // R4: enable mask sweep
    cfg_ep_en = 4'b0101;
    for (int e = 0; e < NEP; e++)
      for (int d = 0; d < 2; d++) begin
        set_own_all();
        a0 = acc_cnt;
        do_req(e, d);
        if (cfg_ep_en[e]) begin
          chk("R4 enabled ok", 64'(r_ok), 64'd1);
          complete(10'd9);
        end else begin
          chk("R4 disabled reject", 64'(r_rej), 64'd1);
          chk("R4 no memory access", 64'(acc_cnt - a0), 64'd0);
        end
      end

    // R5: host mode
    cfg_ep_en = '1;
    cfg_host = 1'b1;
    for (int e = 0; e < NEP; e++)
      for (int d = 0; d < 2; d++) begin
        set_own_all();
        a0 = acc_cnt;
        do_req(e, d);
        if (e == 0) begin
          chk("R5 ep0 ok", 64'(r_ok), 64'd1);
          complete(10'd6);
        end else begin
          chk("R5 host reject", 64'(r_rej), 64'd1);
          chk("R5 no memory access", 64'(acc_cnt - a0), 64'd0);
        end
      end
    cfg_host = 1'b0;

    // R9: request while busy is dropped
    set_own_all();
    do_req(1, 1);
    chk("R9 ok", 64'(r_ok), 64'd1);
    chk("R9 not ready while busy", 64'(req_ready), 64'd0);
    a0 = acc_cnt; r0 = rsp_cnt;
    req_valid = 1'b1; req_ep = 2'd3; req_tx = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9 no memory access", 64'(acc_cnt - a0), 64'd0);
    complete(10'd2);
    repeat (5) @(negedge clk);
    chk("R9 no response", 64'(rsp_cnt - r0), 64'd0);
    chk("R9 only write-back", 64'(acc_cnt - a0), 64'd1);

    finish_run();
  end
endmodule